// File: doc/BRIEF.md
# Immediate-Offset Load/Store Address Generator

This block sits after instruction decode in a pipeline. It accepts one single-register memory transfer word that carries a 12-bit immediate offset, together with the current value of the base register. One cycle later it presents the memory address to use and the access attributes: direction, byte or word size, and whether the access must run with user privilege. It also reports whether the base register must be updated, and with what value. Three addressing styles are chosen by the indexing bits: plain offset, pre-indexed with update, and post-indexed. In the post-indexed style the update always happens, and the W bit is reused to force an unprivileged transfer.

Forms the block does not handle are flagged as illegal, and any base update is suppressed for them. These are register-offset words, words outside the single-transfer class, and words that would update the program counter through the base. The caller supplies the base value already resolved. When the base register is the program counter (index 15), that value is the instruction address plus 8. The condition field and the transfer register field play no part here.

Top module: `ldst_agen`

## Requirements
- R1: While reset is asserted and after it is released, before any valid input, out_valid, wb_en, is_load, is_byte, user_access and illegal are 0, and addr and wb_value are 0.
- R2: out_valid rises in the cycle after a cycle with in_valid high, with all results for that word. After a cycle with in_valid low, out_valid is 0 and addr, wb_value, wb_en and the flags keep their previous values.
- R3: The offset is the unsigned value of bits 11:0 (0 to 4095). With bit 23 set it is added to the base; with bit 23 clear it is subtracted. The arithmetic is modulo 2^ADDR_W, and wb_value always equals this base±offset.
- R4: With bit 24 set, addr is base±offset, and wb_en follows bit 21.
- R5: With bit 24 clear, addr is the unmodified base, and the base update is always requested.
- R6: user_access is 1 exactly when bit 24 is 0 and bit 21 is 1.
- R7: is_load equals bit 20 (1 = load) and is_byte equals bit 22 (1 = unsigned byte).
- R8: illegal is 1 when bit 25 is 1 (register offset) or bits 27:26 differ from 2'b01. While illegal is 1, wb_en is 0.
- R9: A requested base update with bits 19:16 equal to 15 sets illegal and clears wb_en. The same base index with no update requested is legal.
- R10: Bits 31:28 and bits 15:12 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Instruction word and base are valid this cycle |
| instr | input | 32 | Single transfer instruction word |
| base | input | ADDR_W | Resolved base register value |
| out_valid | output | 1 | Results below belong to the word accepted last cycle |
| addr | output | ADDR_W | Memory address of the transfer |
| wb_en | output | 1 | Base register must be updated |
| wb_value | output | ADDR_W | Value for the base register update |
| is_load | output | 1 | 1 = load, 0 = store |
| is_byte | output | 1 | 1 = unsigned byte, 0 = word |
| user_access | output | 1 | Transfer runs with user privilege |
| illegal | output | 1 | Unsupported or forbidden form |

## Verification
The two functions that can coincide are the base update and the illegal-form detection. A post-indexed or pre-indexed word on base index 15 asks for an update and also trips the program-counter rule. The same holds for any update-requesting word with bit 25 set. The sweep crosses every indexing, size and direction combination with base index 0, 5 and 15 and with both values of bit 25, so these clashes occur across many vectors. Each one is judged by requiring illegal to be 1 and wb_en to be 0, while addr, wb_value and user_access still follow their normal rules.

// File: rtl/agen_pkg.sv
package agen_pkg;
   // Bit positions of the transfer word; the decoder depends on them.
   localparam int unsigned INSTR_W   = 32;
   localparam int unsigned OFS_W     = 12;
   localparam int unsigned RIDX_W    = 4;
   localparam int unsigned POS_RN    = 16;
   localparam int unsigned POS_LOAD  = 20;
   localparam int unsigned POS_WBIT  = 21;
   localparam int unsigned POS_BYTE  = 22;
   localparam int unsigned POS_UP    = 23;
   localparam int unsigned POS_PRE   = 24;
   localparam int unsigned POS_IMM   = 25;
   localparam int unsigned POS_CLASS = 26;
   localparam logic [1:0]  CLASS_SINGLE = 2'b01;

   typedef struct packed {
      logic              reg_ofs;
      logic              pre;
      logic              up;
      logic              byte_sz;
      logic              wbit;
      logic              load;
      logic [1:0]        cls;
      logic [RIDX_W-1:0] rn;
      logic [OFS_W-1:0]  ofs;
   } xfer_fields_t;

   typedef struct packed {
      logic wb_req;
      logic user;
      logic bad;
   } xfer_ctl_t;
endpackage

// File: rtl/agen_decode.sv
module agen_decode
   import agen_pkg::*;
#(
   parameter int unsigned PC_IDX = 15
) (
   input  logic [INSTR_W-1:0] instr,
   output xfer_fields_t       fields,
   output xfer_ctl_t          ctl
);
   logic unused_bits;
   logic bad_form;
   logic pc_update;

   assign fields.reg_ofs = instr[POS_IMM];
   assign fields.pre     = instr[POS_PRE];
   assign fields.up      = instr[POS_UP];
   assign fields.byte_sz = instr[POS_BYTE];
   assign fields.wbit    = instr[POS_WBIT];
   assign fields.load    = instr[POS_LOAD];
   assign fields.cls     = instr[POS_CLASS +: 2];
   assign fields.rn      = instr[POS_RN +: RIDX_W];
   assign fields.ofs     = instr[OFS_W-1:0];

   // Condition and transfer register fields are resolved elsewhere.
   assign unused_bits = ^{instr[INSTR_W-1:POS_CLASS+2], instr[POS_RN-1:OFS_W]};

   always_comb begin
      // Post-indexed always updates; pre-indexed updates on W.
      ctl.wb_req = !fields.pre || fields.wbit;
      // W without pre-indexing means unprivileged transfer.
      ctl.user   = !fields.pre && fields.wbit;
      bad_form   = fields.reg_ofs || (fields.cls != CLASS_SINGLE);
      pc_update  = ctl.wb_req && (fields.rn == RIDX_W'(PC_IDX));
      ctl.bad    = bad_form || pc_update;
   end
endmodule

// File: rtl/agen_offset_adder.sv
module agen_offset_adder
   import agen_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          ADDER_SHARED = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [OFS_W-1:0]  ofs,
   input  logic              up,
   output logic [ADDR_W-1:0] sum
);
   localparam int unsigned EXT_W = ADDR_W - OFS_W;

   logic [ADDR_W-1:0] ofs_ext;
   assign ofs_ext = {{EXT_W{1'b0}}, ofs};

   generate
      if (ADDER_SHARED) begin : g_shared
         // One carry chain: subtract as base + ~ofs + 1.
         logic [ADDR_W-1:0] operand;
         logic [ADDR_W-1:0] cin;
         assign operand = up ? ofs_ext : ~ofs_ext;
         assign cin     = {{(ADDR_W-1){1'b0}}, !up};
         assign sum     = base + operand + cin;
      end else begin : g_split
         // Two carry chains in parallel, direction bit picks late.
         logic [ADDR_W-1:0] plus_v;
         logic [ADDR_W-1:0] minus_v;
         assign plus_v  = base + ofs_ext;
         assign minus_v = base - ofs_ext;
         assign sum     = up ? plus_v : minus_v;
      end
   endgenerate
endmodule

// File: rtl/agen_out_reg.sv
module agen_out_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] addr_d,
   input  logic [ADDR_W-1:0] wbv_d,
   input  logic              wb_en_d,
   input  logic              load_d,
   input  logic              byte_d,
   input  logic              user_d,
   input  logic              bad_d,
   output logic              valid_q,
   output logic [ADDR_W-1:0] addr_q,
   output logic [ADDR_W-1:0] wbv_q,
   output logic              wb_en_q,
   output logic              load_q,
   output logic              byte_q,
   output logic              user_q,
   output logic              bad_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         addr_q  <= '0;
         wbv_q   <= '0;
         wb_en_q <= 1'b0;
         load_q  <= 1'b0;
         byte_q  <= 1'b0;
         user_q  <= 1'b0;
         bad_q   <= 1'b0;
      end else begin
         valid_q <= load_en;
         if (load_en) begin
            addr_q  <= addr_d;
            wbv_q   <= wbv_d;
            wb_en_q <= wb_en_d;
            load_q  <= load_d;
            byte_q  <= byte_d;
            user_q  <= user_d;
            bad_q   <= bad_d;
         end
      end
   end
endmodule

// File: rtl/ldst_agen.sv
module ldst_agen
   import agen_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter int unsigned PC_IDX       = 15,
   parameter bit          ADDER_SHARED = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                in_valid,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [ADDR_W-1:0]   base,
   output logic                out_valid,
   output logic [ADDR_W-1:0]   addr,
   output logic                wb_en,
   output logic [ADDR_W-1:0]   wb_value,
   output logic                is_load,
   output logic                is_byte,
   output logic                user_access,
   output logic                illegal
);
   generate
      if (ADDR_W <= OFS_W) begin : g_bad_width
         $error("ldst_agen: ADDR_W must exceed the offset width");
      end
      if (PC_IDX >= (1 << RIDX_W)) begin : g_bad_pc
         $error("ldst_agen: PC_IDX out of register index range");
      end
   endgenerate

   xfer_fields_t      fields;
   xfer_ctl_t         ctl;
   logic [ADDR_W-1:0] sum;
   logic [ADDR_W-1:0] addr_d;
   logic              wb_en_d;

   agen_decode #(.PC_IDX(PC_IDX)) u_decode (
      .instr  (instr),
      .fields (fields),
      .ctl    (ctl)
   );

   agen_offset_adder #(
      .ADDR_W       (ADDR_W),
      .ADDER_SHARED (ADDER_SHARED)
   ) u_adder (
      .base (base),
      .ofs  (fields.ofs),
      .up   (fields.up),
      .sum  (sum)
   );

   assign addr_d  = fields.pre ? sum : base;
   assign wb_en_d = ctl.wb_req && !ctl.bad;

   agen_out_reg #(.ADDR_W(ADDR_W)) u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_en (in_valid),
      .addr_d  (addr_d),
      .wbv_d   (sum),
      .wb_en_d (wb_en_d),
      .load_d  (fields.load),
      .byte_d  (fields.byte_sz),
      .user_d  (ctl.user),
      .bad_d   (ctl.bad),
      .valid_q (out_valid),
      .addr_q  (addr),
      .wbv_q   (wb_value),
      .wb_en_q (wb_en),
      .load_q  (is_load),
      .byte_q  (is_byte),
      .user_q  (user_access),
      .bad_q   (illegal)
   );
endmodule

// File: rtl/ldst_agen_chk.sv
module ldst_agen_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned PC_IDX = 15
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic [31:0]       instr,
   input logic [ADDR_W-1:0] base,
   input logic              out_valid,
   input logic [ADDR_W-1:0] addr,
   input logic              wb_en,
   input logic [ADDR_W-1:0] wb_value,
   input logic              is_load,
   input logic              is_byte,
   input logic              user_access,
   input logic              illegal
);
   a_r2_valid_follow: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> out_valid);
   a_r2_idle_drop: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !out_valid);
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(addr) && $stable(wb_value) && $stable(wb_en)
                     && $stable(illegal)));
   a_r5_post_uses_base: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !instr[24]) |=> (addr == $past(base)));
   a_r6_user_updates: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && user_access && !illegal) |-> wb_en);
   a_r7_load_flag: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (is_load == $past(instr[20]) && is_byte == $past(instr[22])));
   a_r8_illegal_blocks_wb: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && illegal) |-> !wb_en);
   a_r9_no_pc_update: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && instr[19:16] == 4'(PC_IDX)) |=> !wb_en);
endmodule

bind ldst_agen ldst_agen_chk #(.ADDR_W(ADDR_W), .PC_IDX(PC_IDX)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .instr       (instr),
   .base        (base),
   .out_valid   (out_valid),
   .addr        (addr),
   .wb_en       (wb_en),
   .wb_value    (wb_value),
   .is_load     (is_load),
   .is_byte     (is_byte),
   .user_access (user_access),
   .illegal     (illegal)
);

// File: tb/tb_ldst_agen.sv
module tb_ldst_agen;
   localparam int unsigned AW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [31:0]   instr = '0;
   logic [AW-1:0] base = '0;
   logic          out_valid, wb_en, is_load, is_byte, user_access, illegal;
   logic [AW-1:0] addr, wb_value;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   ldst_agen dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr), .base(base),
      .out_valid(out_valid), .addr(addr), .wb_en(wb_en), .wb_value(wb_value),
      .is_load(is_load), .is_byte(is_byte), .user_access(user_access),
      .illegal(illegal)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Drive one word at the falling edge, sample its result one edge later.
   task automatic apply(input logic [31:0] w, input logic [AW-1:0] b);
      @(negedge clk);
      in_valid = 1'b1; instr = w; base = b;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic expect_word(input logic [31:0] w, input logic [AW-1:0] b);
      logic p, u, wb, iv, req, bad;
      logic [AW-1:0] s;
      p  = w[24]; u = w[23]; wb = w[21]; iv = w[25];
      s  = u ? b + AW'(w[11:0]) : b - AW'(w[11:0]);
      req = !p || wb;
      bad = iv || (w[27:26] != 2'b01) || (req && w[19:16] == 4'd15);
      chk("R2 out_valid", 64'(out_valid), 64'd1);
      chk("R3 wb_value", 64'(wb_value), 64'(s));
      chk(p ? "R4 addr" : "R5 addr", 64'(addr), 64'(p ? s : b));
      chk("R4/R5 R8 R9 wb_en", 64'(wb_en), 64'(req && !bad));
      chk("R6 user_access", 64'(user_access), 64'(!p && wb));
      chk("R7 is_load", 64'(is_load), 64'(w[20]));
      chk("R7 is_byte", 64'(is_byte), 64'(w[22]));
      chk("R8 R9 illegal", 64'(illegal), 64'(bad));
   endtask

   initial begin
      logic [AW-1:0] bases [4];
      logic [11:0]   offs  [4];
      logic [3:0]    rns   [3];
      bases[0] = 32'h0000_0000; offs[0] = 12'h000;
      bases[1] = 32'h0000_0010; offs[1] = 12'h020;
      bases[2] = 32'hFFFF_FFF0; offs[2] = 12'hFFF;
      bases[3] = 32'h0000_1000; offs[3] = 12'hFFF;
      rns[0] = 4'd0; rns[1] = 4'd5; rns[2] = 4'd15;

      // R1: reset state
      repeat (3) @(negedge clk);
      chk("R1 out_valid in reset", 64'(out_valid), 0);
      chk("R1 flags in reset", 64'({wb_en, is_load, is_byte, user_access, illegal}), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 out_valid after reset", 64'(out_valid), 0);
      chk("R1 addr after reset", 64'(addr), 0);
      chk("R1 wb_value after reset", 64'(wb_value), 0);

      // Sweep: P,U,B,W,L and I, three base indices, four base/offset pairs.
      for (int m = 0; m < 64; m++) begin
         for (int r = 0; r < 3; r++) begin
            for (int k = 0; k < 4; k++) begin
               logic [31:0] w;
               w = {4'(m + k), 2'b01, 6'(m), rns[r], 4'(m ^ k), offs[k]};
               apply(w, bases[k]);
               expect_word(w, bases[k]);
            end
         end
      end

      // R8: words outside the single transfer class
      for (int c = 0; c < 4; c++) begin
         logic [31:0] w;
         w = {4'hE, 2'(c), 6'b011010, 4'd3, 4'd1, 12'h004};
         apply(w, 32'h100);
         expect_word(w, 32'h100);
      end

      // R9: base index 15 without update is legal
      apply({4'hE, 2'b01, 6'b011001, 4'd15, 4'd2, 12'h008}, 32'h2008);
      chk("R9 pc no-update legal", 64'(illegal), 0);
      chk("R9 pc no-update addr", 64'(addr), 64'h2010);

      // R10: condition and Rd fields do not change outputs
      for (int c = 0; c < 16; c++) begin
         logic [31:0] w;
         w = {4'(c), 2'b01, 6'b001011, 4'd7, 4'(15 - c), 12'h123};
         apply(w, 32'h8000);
         chk("R10 addr", 64'(addr), 64'h8000);
         chk("R10 wb_value", 64'(wb_value), 64'h8123);
         chk("R10 flags", 64'({wb_en, is_load, is_byte, user_access, illegal}), 64'b11010);
      end

      // R2: outputs hold and out_valid drops while idle
      apply({4'hE, 2'b01, 6'b011000, 4'd1, 4'd0, 12'h010}, 32'h500);
      @(negedge clk);
      instr = 32'hE5B0_0FFF; base = 32'h1234_5678;
      @(negedge clk);
      chk("R2 out_valid idle", 64'(out_valid), 0);
      chk("R2 addr held", 64'(addr), 64'h510);
      chk("R2 wb_value held", 64'(wb_value), 64'h510);
      chk("R2 wb_en held", 64'(wb_en), 0);

      done = 1'b1;
   end

   initial begin
      fork
         begin
            wait (done);
         end
         begin
            repeat (100000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule